// File: doc/BRIEF.md
# Gated SPI Slave Character Receiver

This block is the receive side of a four-pin SPI slave. It runs on a fast system clock and treats the serial clock, the serial data line and the active-low slave select as asynchronous pins. It brings them into the system domain and detects serial-clock rising edges there. It shifts in one character, most significant bit first, and hands the character to a receive buffer together with an interrupt flag.

Reception is controlled by four states: off, idle, shifting and handling. Leaving the off state requires the enable bit. A new character starts only while the enable bit is 1, the slave select is low and a serial-clock edge arrives. Once a character has begun, it finishes even if the enable bit is cleared. It pauses without losing bits while the serial clock stops or while the slave select is high. After each character there is one handling cycle. That cycle returns the receiver to idle if the enable bit is still 1, and to off if it is 0.

Top module: `spi_rx_gate`

## Requirements
- R1: `rst` (power-up clear) clears `rx_data` to 0x00 and `rx_flag` to 0 and places the receiver in the off state. `soft_rst` places the receiver in the off state, clears `rx_flag` and discards any partial character, but leaves `rx_data` unchanged.
- R2: A receiver in the off state never collects bits. With `rx_en` = 0, a full character clocked in while the receiver is off leaves `rx_flag` and `rx_data` unchanged.
- R3: With `rx_en` = 1 and `ssel_n` = 0, eight serial-clock rising edges deliver one character. The bit sampled at the first edge lands in `rx_data[7]` and the bit sampled at the last edge lands in `rx_data[0]`.
- R4: A serial-clock rising edge seen while `ssel_n` = 1 shifts nothing and does not advance the bit count. A partial character continues where it stopped once `ssel_n` returns low.
- R5: If the serial clock stops mid-character, the partial bits are held for any length of time and the character completes when the edges resume.
- R6: The pins pass through a two-stage synchronizer. On the third system-clock rising edge after the eighth serial-clock rise, `rx_data` takes the new character and `rx_flag` is set.
- R7: A one-cycle `rd_strobe` pulse clears `rx_flag` on the next edge. When a completion falls in the same cycle, setting the flag wins.
- R8: After a character, the receiver goes back to idle if `rx_en` = 1, so back-to-back characters are received. If `rx_en` was cleared during a character, that character still completes, and later characters are ignored until `rx_en` is set again.
- R9: `rx_data` changes only when a character completes, or on `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-up clear |
| soft_rst | input | 1 | Synchronous software reset of the receiver |
| rx_en | input | 1 | Receive enable bit (1 = enabled) |
| sclk_in | input | 1 | External serial clock pin |
| sdi_in | input | 1 | Serial data pin |
| ssel_n_in | input | 1 | Active-low slave select pin |
| rd_strobe | input | 1 | Buffer read pulse; clears the flag |
| rx_data | output | 8 | Receive buffer |
| rx_flag | output | 1 | Receive interrupt flag |

## Verification
The bound checker watches, on every clock:
- that the off state never leads straight into shifting;
- that the bit count freezes while the slave select is high;
- that the shifting state persists while no serial-clock edge arrives;
- that the handling state exits according to the enable bit;
- that the buffer is stable except on completions;
- the flag's set and clear rules, including after a software reset.

Some behaviour only the bench's scenarios can show:
- the bit order of a character;
- the exact three-cycle latency;
- a character that is finished after the enable bit is cleared;
- a partial character thrown away by a software reset;
- a character resumed after a long stop of the serial clock.

The bench shows these by comparing against a behavioural model on every cycle and by directed checks.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  localparam int CHAR_W = 8;

  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_IDLE   = 2'd1,
    ST_SHIFT  = 2'd2,
    ST_HANDLE = 2'd3
  } rx_state_t;
endpackage

// File: rtl/spi_rx_sync.sv
module spi_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_in,
  input  logic sdi_in,
  input  logic ssel_n_in,
  output logic sclk_rise,
  output logic sdi_q,
  output logic ssel_n_q
);
  // bit 2 = serial clock, bit 1 = data, bit 0 = select (reset to inactive)
  localparam logic [2:0] PIN_RESET = 3'b001;

  logic [2:0] pipe [STAGES];
  logic       sclk_prev;

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= PIN_RESET;
    else     pipe[0] <= {sclk_in, sdi_in, ssel_n_in};
  end

  genvar g;
  generate
    for (g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= PIN_RESET;
        else     pipe[g] <= pipe[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) sclk_prev <= 1'b0;
    else     sclk_prev <= pipe[STAGES-1][2];
  end

  assign sclk_rise = pipe[STAGES-1][2] & ~sclk_prev;
  assign sdi_q     = pipe[STAGES-1][1];
  assign ssel_n_q  = pipe[STAGES-1][0];
endmodule

// File: rtl/spi_rx_ctrl.sv
module spi_rx_ctrl
  import spi_rx_pkg::*;
#(
  parameter int W = CHAR_W,
  localparam int CNT_W = $clog2(W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_rst,
  input  logic             rx_en,
  input  logic             sclk_rise,
  input  logic             ssel_n_q,
  output logic             shift_en,
  output logic             done,
  output rx_state_t        state,
  output logic [CNT_W-1:0] bit_cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic edge_ok;
  assign edge_ok  = sclk_rise & ~ssel_n_q;
  assign shift_en = edge_ok & ((state == ST_IDLE && rx_en) || state == ST_SHIFT);
  assign done     = shift_en && state == ST_SHIFT && bit_cnt == LAST;

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      state   <= ST_OFF;
      bit_cnt <= '0;
    end else begin
      case (state)
        ST_OFF: if (rx_en) state <= ST_IDLE;
        ST_IDLE: begin
          if (!rx_en) state <= ST_OFF;
          else if (shift_en) begin
            state   <= ST_SHIFT;
            bit_cnt <= CNT_W'(1);
          end
        end
        ST_SHIFT: begin
          if (done) begin
            state   <= ST_HANDLE;
            bit_cnt <= '0;
          end else if (shift_en) begin
            bit_cnt <= bit_cnt + CNT_W'(1);
          end
        end
        default: state <= rx_en ? ST_IDLE : ST_OFF;
      endcase
    end
  end
endmodule

// File: rtl/spi_rx_buffer.sv
module spi_rx_buffer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         soft_rst,
  input  logic         shift_en,
  input  logic         done,
  input  logic         sdi_q,
  input  logic         rd_strobe,
  output logic [W-1:0] rx_data,
  output logic         rx_flag
);
  logic [W-2:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else if (shift_en) shreg <= {shreg[W-3:0], sdi_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data <= '0;
      rx_flag <= 1'b0;
    end else if (soft_rst) begin
      rx_flag <= 1'b0;
    end else begin
      if (done) rx_data <= {shreg, sdi_q};
      if (done)           rx_flag <= 1'b1;
      else if (rd_strobe) rx_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_rx_gate.sv
module spi_rx_gate
  import spi_rx_pkg::*;
#(
  parameter int W          = CHAR_W,
  parameter int SYNC_DEPTH = 2,
  localparam int CNT_W     = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         soft_rst,
  input  logic         rx_en,
  input  logic         sclk_in,
  input  logic         sdi_in,
  input  logic         ssel_n_in,
  input  logic         rd_strobe,
  output logic [W-1:0] rx_data,
  output logic         rx_flag
);
  logic             sclk_rise, sdi_q, ssel_n_q, shift_en, done;
  rx_state_t        state;
  logic [CNT_W-1:0] bit_cnt;

  spi_rx_sync #(.STAGES(SYNC_DEPTH)) i_sync (
    .clk(clk), .rst(rst), .sclk_in(sclk_in), .sdi_in(sdi_in),
    .ssel_n_in(ssel_n_in), .sclk_rise(sclk_rise), .sdi_q(sdi_q),
    .ssel_n_q(ssel_n_q)
  );

  spi_rx_ctrl #(.W(W)) i_ctrl (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .rx_en(rx_en),
    .sclk_rise(sclk_rise), .ssel_n_q(ssel_n_q), .shift_en(shift_en),
    .done(done), .state(state), .bit_cnt(bit_cnt)
  );

  spi_rx_buffer #(.W(W)) i_buf (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .shift_en(shift_en),
    .done(done), .sdi_q(sdi_q), .rd_strobe(rd_strobe),
    .rx_data(rx_data), .rx_flag(rx_flag)
  );
endmodule

// File: rtl/spi_rx_gate_chk.sv
module spi_rx_gate_chk
  import spi_rx_pkg::*;
#(
  parameter int W = CHAR_W,
  localparam int CNT_W = $clog2(W + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             soft_rst,
  input logic             rx_en,
  input logic             rd_strobe,
  input logic [W-1:0]     rx_data,
  input logic             rx_flag,
  input logic             done,
  input logic             sclk_rise,
  input logic             ssel_n_q,
  input rx_state_t        state,
  input logic [CNT_W-1:0] bit_cnt
);
  assert_soft_reset_clears_flag_R1: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> !rx_flag);

  assert_off_never_shifts_R2: assert property (@(posedge clk) disable iff (rst)
    state == ST_OFF |=> state != ST_SHIFT);

  assert_select_high_holds_count_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHIFT && ssel_n_q && !soft_rst) |=> $stable(bit_cnt));

  assert_no_edge_stays_shifting_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHIFT && !sclk_rise && !soft_rst) |=> state == ST_SHIFT);

  assert_flag_rise_from_done_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_flag) |-> $past(done));

  assert_read_clears_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && !done) |=> !rx_flag);

  assert_handle_exit_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HANDLE && !soft_rst) |=> (rx_en ? state == ST_IDLE : state == ST_OFF));

  assert_buffer_stable_R9: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(rx_data));
endmodule

bind spi_rx_gate spi_rx_gate_chk #(.W(W)) i_chk (
  .clk(clk), .rst(rst), .soft_rst(soft_rst), .rx_en(rx_en),
  .rd_strobe(rd_strobe), .rx_data(rx_data), .rx_flag(rx_flag),
  .done(done), .sclk_rise(sclk_rise), .ssel_n_q(ssel_n_q),
  .state(state), .bit_cnt(bit_cnt)
);

// File: tb/test_spi_rx_gate.sv
module test_spi_rx_gate;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1, soft_rst = 1'b0, rx_en = 1'b0;
  logic sclk_in = 1'b0, sdi_in = 1'b0, ssel_n_in = 1'b1, rd_strobe = 1'b0;
  logic [7:0] rx_data;
  logic rx_flag;

  int checks = 0, fails = 0, cycles = 0;

  spi_rx_gate i_spi_rx_gate (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .rx_en(rx_en),
    .sclk_in(sclk_in), .sdi_in(sdi_in), .ssel_n_in(ssel_n_in),
    .rd_strobe(rd_strobe), .rx_data(rx_data), .rx_flag(rx_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural model: pin history with two-cycle synchronizer delay
  bit h_sclk[$], h_sdi[$], h_ss[$];
  int m_mode = 0; // 0 off, 1 idle, 2 shifting, 3 handling
  int m_cnt = 0;
  int m_shift = 0;
  int m_data = 0;
  bit m_flag = 0;

  task automatic hist_reset();
    h_sclk = '{0, 0, 0}; h_sdi = '{0, 0, 0}; h_ss = '{1, 1, 1};
  endtask

  initial hist_reset();

  always @(posedge clk) begin
    bit rise, d, ss, load;
    rise = h_sclk[1] && !h_sclk[2];
    d = h_sdi[1]; ss = h_ss[1];
    load = 0;
    if (rst) begin
      m_mode = 0; m_cnt = 0; m_data = 0; m_flag = 0; m_shift = 0;
      hist_reset();
    end else begin
      if (soft_rst) begin
        m_mode = 0; m_cnt = 0; m_flag = 0;
      end else begin
        if (m_mode == 0) begin
          if (rx_en) m_mode = 1;
        end else if (m_mode == 1) begin
          if (!rx_en) m_mode = 0;
          else if (rise && !ss) begin m_shift = d; m_cnt = 1; m_mode = 2; end
        end else if (m_mode == 2) begin
          if (rise && !ss) begin
            m_shift = (m_shift * 2 + d) % 256;
            m_cnt++;
            if (m_cnt == 8) begin m_data = m_shift; load = 1; m_cnt = 0; m_mode = 3; end
          end
        end else begin
          m_mode = rx_en ? 1 : 0;
        end
        if (load) m_flag = 1;
        else if (rd_strobe) m_flag = 0;
      end
      void'(h_sclk.pop_back()); void'(h_sdi.pop_back()); void'(h_ss.pop_back());
      h_sclk.push_front(sclk_in); h_sdi.push_front(sdi_in); h_ss.push_front(ssel_n_in);
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model (R6 latency, R7, R9)
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      check(rx_data == m_data[7:0], "R6/R9 model data", int'(rx_data), m_data);
      check(rx_flag == m_flag, "R7 model flag", int'(rx_flag), int'(m_flag));
    end
    if (cycles > WATCHDOG) begin
      check(0, "watchdog", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(bit b);
    @(negedge clk); sdi_in = b; sclk_in = 1'b0;
    wait_cyc(3);
    sclk_in = 1'b1;
    wait_cyc(4);
    sclk_in = 1'b0;
  endtask

  task automatic send_bits(logic [7:0] v, int from_bit, int to_bit);
    for (int i = from_bit; i >= to_bit; i--) send_bit(v[i]);
  endtask

  task automatic pulse_read();
    @(negedge clk); rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0;
  endtask

  initial begin
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(1);
    // R1: reset state
    check(rx_data == 8'h00, "R1 reset data", int'(rx_data), 0);
    check(rx_flag == 1'b0, "R1 reset flag", int'(rx_flag), 0);

    // R2: disabled receiver ignores a full character
    ssel_n_in = 1'b0;
    send_bits(8'hA5, 7, 0);
    wait_cyc(6);
    check(rx_flag == 1'b0, "R2 disabled flag", int'(rx_flag), 0);
    check(rx_data == 8'h00, "R2 disabled data", int'(rx_data), 0);

    // R3/R6: enabled character, MSB first, exact latency
    rx_en = 1'b1;
    wait_cyc(2);
    send_bits(8'h3C, 7, 1);
    @(negedge clk); sdi_in = 1'b0; wait_cyc(3); sclk_in = 1'b1;
    wait_cyc(2);
    check(rx_flag == 1'b0, "R6 not yet after two edges", int'(rx_flag), 0);
    wait_cyc(1);
    check(rx_flag == 1'b1, "R6 flag on third edge", int'(rx_flag), 1);
    check(rx_data == 8'h3C, "R3 character", int'(rx_data), 8'h3C);
    wait_cyc(2); sclk_in = 1'b0;

    // R7: read clears flag
    pulse_read();
    wait_cyc(1);
    check(rx_flag == 1'b0, "R7 read clears", int'(rx_flag), 0);

    // R4: select high pauses a partial character
    send_bits(8'hC9, 7, 5);
    @(negedge clk); ssel_n_in = 1'b1; wait_cyc(3);
    send_bits(8'hFF, 7, 3);
    @(negedge clk); ssel_n_in = 1'b0; wait_cyc(3);
    send_bits(8'hC9, 4, 0);
    wait_cyc(6);
    check(rx_data == 8'hC9, "R4 resumed character", int'(rx_data), 8'hC9);
    pulse_read();

    // R5: serial clock stops mid-character
    send_bits(8'h96, 7, 4);
    wait_cyc(300);
    check(rx_flag == 1'b0, "R5 no flag while paused", int'(rx_flag), 0);
    check(rx_data == 8'hC9, "R9 buffer held while paused", int'(rx_data), 8'hC9);
    send_bits(8'h96, 3, 0);
    wait_cyc(6);
    check(rx_data == 8'h96, "R5 completed after pause", int'(rx_data), 8'h96);

    // R1: soft reset discards partial, keeps buffer
    send_bits(8'h00, 7, 3);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    wait_cyc(1);
    check(rx_flag == 1'b0, "R1 soft reset flag", int'(rx_flag), 0);
    check(rx_data == 8'h96, "R1 soft reset keeps buffer", int'(rx_data), 8'h96);
    wait_cyc(2);
    send_bits(8'h5A, 7, 0);
    wait_cyc(6);
    check(rx_data == 8'h5A, "R1 fresh character after soft reset", int'(rx_data), 8'h5A);

    // R8: back-to-back characters
    send_bits(8'h11, 7, 0);
    wait_cyc(4);
    check(rx_data == 8'h11, "R8 back-to-back first", int'(rx_data), 8'h11);
    send_bits(8'hE7, 7, 0);
    wait_cyc(4);
    check(rx_data == 8'hE7, "R8 back-to-back second", int'(rx_data), 8'hE7);
    pulse_read();

    // R8: enable cleared mid-character, character still completes
    send_bits(8'h6E, 7, 4);
    @(negedge clk); rx_en = 1'b0;
    send_bits(8'h6E, 3, 0);
    wait_cyc(6);
    check(rx_data == 8'h6E, "R8 completes after disable", int'(rx_data), 8'h6E);
    pulse_read();
    send_bits(8'hFF, 7, 0);
    wait_cyc(6);
    check(rx_data == 8'h6E, "R8 ignored while disabled", int'(rx_data), 8'h6E);
    check(rx_flag == 1'b0, "R8 no flag while disabled", int'(rx_flag), 0);
    rx_en = 1'b1;
    wait_cyc(3);
    send_bits(8'h81, 7, 0);
    wait_cyc(6);
    check(rx_data == 8'h81, "R8 re-enabled character", int'(rx_data), 8'h81);

    // R7: read pulse in the completion cycle, set wins (model covers exact cycle)
    send_bits(8'h42, 7, 1);
    @(negedge clk); sdi_in = 1'b0; wait_cyc(3); sclk_in = 1'b1;
    wait_cyc(2); rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0;
    check(rx_flag == 1'b1, "R7 set wins over read", int'(rx_flag), 1);
    check(rx_data == 8'h42, "R3 last character", int'(rx_data), 8'h42);
    sclk_in = 1'b0;
    wait_cyc(4);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule